// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

A register-mapped watchdog that counts down a programmable number of prescaled ticks. When the count runs out the first time, it flags a status bit and raises a one-cycle SMI pulse. If it runs out a second time with no reload in between, it asks the platform to reset. Two conditions block that reset: a speaker strap input held high, or a no-reboot configuration input. In those cases the second expiry behaves like the first, apart from extra status bits.

Software reaches the block through a window of halfword registers with byte-lane enables. The window holds the countdown, the timeout, two status words, two control words, a data-in and data-out mailbox, two message bytes and two scratch bytes. Firmware pets the watchdog by writing the reload register. It can halt the countdown through control word 1 and can freeze that setting with a lock bit. Reads are combinational on the address.

Top module: `wdog_two_stage`

## Requirements
- R1: Halfword index map: 0 reload, 1 timeout, 2 status1, 3 status2, 4 control1, 5 control2, 6 mailbox (low byte data-in, high byte data-out), 7 messages (low msg1, high msg2), 8 scratch (low watchdog count, high software-IRQ). After reset, index 1 reads 0x0004, index 5 reads 0x0008, index 8 reads 0x0300, every other index reads 0, and neither SMI nor reset request is active.
- R2: The countdown runs only while control1 bit 0 (halt) is clear and the timeout exceeds 1. A write to control1 restarts the count from the timeout when that condition holds for the new value, and otherwise stops it. The timer does not run out of reset until it is started.
- R3: While running, each tick lowers the low TMR_W bits of the reload register by one and leaves its upper bits unchanged, so reading index 0 returns the remaining ticks.
- R4: On a tick that finds the count at 1 or below (first expiry), status1 bit 0 is set, SMI pulses, and the count reloads from the timeout and keeps running.
- R5: On a second expiry with strap low and no-reboot low, status2 bits 0 and 1 are set, the reload register clears, counting stops, no SMI is raised, and the reset request rises and stays high until reset.
- R6: On a second expiry with the strap high or no-reboot high, status2 bits 0 and 1 are set, SMI pulses when enabled, and the count reloads. The next expiry after that counts as a first expiry again.
- R7: Any write to the reload register clears the expiry count. It restarts the count from the timeout when the run condition holds, and otherwise stores the written value.
- R8: Control1 bit 1 (lock) can be set by software but not cleared; only reset clears it.
- R9: Writing the data-in byte sets status1 bit 1 and pulses SMI whatever the SMI enable. Writing the data-out byte sets status1 bit 2.
- R10: Writes obey the byte enables. Status1, status2 and control1 keep only their implemented bits (masks 0x0007, 0x0003, 0x0003), and the timeout keeps only its low TMR_W bits.
- R11: In a cycle with any register write, the tick is ignored.
- R12: With SMI enable low, an expiry still sets its status but raises no SMI.
- R13: SMI is a single-cycle pulse in the cycle after the edge that sampled its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled countdown strobe |
| wrEn | input | 1 | Register write request |
| addr | input | ADDR_W | Halfword register index |
| byteEn | input | 2 | Byte-lane write enables |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for addr |
| spkrStrap | input | 1 | Strap; high blocks the reset |
| noReboot | input | 1 | Configuration; high blocks the reset |
| smiEn | input | 1 | Allows expiry SMI pulses |
| smiPulse | output | 1 | One-cycle SMI |
| resetReq | output | 1 | Sticky platform reset request |

## Verification
The bench builds the block with TMR_W = 6. That puts the boundary between counted bits and preserved bits inside the low byte of the reload register. A stored value such as 0xA443 then shows, after one tick, that only the low six bits move. Short timeouts of 2 to 7 ticks let the bench reach many expiries in a few hundred cycles: first, second and third, with the reset either blocked or allowed. A random mix of ticks, pets, timeout and halt writes is compared with a bench model of the countdown and the expiry count.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // halfword register indices
  localparam int HW_RELOAD  = 0;
  localparam int HW_TIMEOUT = 1;
  localparam int HW_STAT1   = 2;
  localparam int HW_STAT2   = 3;
  localparam int HW_CTRL1   = 4;
  localparam int HW_CTRL2   = 5;
  localparam int HW_MAILBOX = 6;
  localparam int HW_MSG     = 7;
  localparam int HW_SCRATCH = 8;

  // bit positions
  localparam int S1_TIMEOUT = 0;
  localparam int S1_SOFTSMI = 1;
  localparam int S1_DOUT    = 2;
  localparam int S2_SECOND  = 0;
  localparam int S2_BOOT    = 1;
  localparam int C1_HALT    = 0;
  localparam int C1_LOCK    = 1;

  typedef struct packed {
    logic wrTimeout;
    logic wrStat1;
    logic wrStat2;
    logic wrCtrl1;
    logic wrCtrl2;
    logic wrDin;
    logic wrDout;
    logic wrMsg1;
    logic wrMsg2;
    logic wrWdcnt;
    logic wrSwIrq;
    logic rldFromTmr;
    logic rldFromBus;
    logic rldDec;
    logic rldClear;
    logic setTimeout;
    logic setSecond;
    logic setSoftSmi;
    logic setDoutInt;
  } wdogStrobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int TMR_W  = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        byteEn,
  input  logic              wrHalt,
  input  logic              tick,
  input  logic              curHalt,
  input  logic [TMR_W-1:0]  tmrVal,
  input  logic [TMR_W-1:0]  cntLow,
  input  logic              spkrStrap,
  input  logic              noReboot,
  input  logic              smiEn,
  output wdogStrobes_t      stb,
  output logic              smiPulse,
  output logic              resetReq
);
  logic anyWr;
  logic tmrAbove1;
  logic newHalt;
  logic running, runNext;
  logic expCnt, expNext;
  logic smiNext, rstNext;

  assign anyWr     = wrEn && (byteEn != 2'b00);
  assign tmrAbove1 = tmrVal > TMR_W'(1);
  assign newHalt   = byteEn[0] ? wrHalt : curHalt;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  always_comb begin
    stb     = '0;
    smiNext = 1'b0;
    runNext = running;
    expNext = expCnt;
    rstNext = resetReq;
    if (anyWr) begin
      stb.wrTimeout = hit(addr, HW_TIMEOUT);
      stb.wrStat1   = hit(addr, HW_STAT1);
      stb.wrStat2   = hit(addr, HW_STAT2);
      stb.wrCtrl1   = hit(addr, HW_CTRL1);
      stb.wrCtrl2   = hit(addr, HW_CTRL2);
      stb.wrMsg1    = hit(addr, HW_MSG) && byteEn[0];
      stb.wrMsg2    = hit(addr, HW_MSG) && byteEn[1];
      stb.wrWdcnt   = hit(addr, HW_SCRATCH) && byteEn[0];
      stb.wrSwIrq   = hit(addr, HW_SCRATCH) && byteEn[1];
      if (hit(addr, HW_RELOAD)) begin
        expNext = 1'b0;
        if (!curHalt && tmrAbove1) begin
          stb.rldFromTmr = 1'b1;
          runNext        = 1'b1;
        end else begin
          stb.rldFromBus = 1'b1;
        end
      end
      if (hit(addr, HW_CTRL1)) begin
        if (!newHalt && tmrAbove1) begin
          stb.rldFromTmr = 1'b1;
          runNext        = 1'b1;
        end else begin
          runNext = 1'b0;
        end
      end
      if (hit(addr, HW_MAILBOX) && byteEn[0]) begin
        stb.wrDin      = 1'b1;
        stb.setSoftSmi = 1'b1;
        smiNext        = 1'b1;
      end
      if (hit(addr, HW_MAILBOX) && byteEn[1]) begin
        stb.wrDout     = 1'b1;
        stb.setDoutInt = 1'b1;
      end
    end else if (tick && running) begin
      if (cntLow <= TMR_W'(1)) begin
        stb.setTimeout = 1'b1;
        if (expCnt) begin
          stb.setSecond = 1'b1;
          expNext       = 1'b0;
          if (!spkrStrap && !noReboot) begin
            stb.rldClear = 1'b1;
            runNext      = 1'b0;
            rstNext      = 1'b1;
          end else begin
            smiNext        = smiEn;
            stb.rldFromTmr = 1'b1;
          end
        end else begin
          expNext        = 1'b1;
          smiNext        = smiEn;
          stb.rldFromTmr = 1'b1;
        end
      end else begin
        stb.rldDec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      expCnt   <= 1'b0;
      smiPulse <= 1'b0;
      resetReq <= 1'b0;
    end else begin
      running  <= runNext;
      expCnt   <= expNext;
      smiPulse <= smiNext;
      resetReq <= rstNext;
    end
  end

  AST_RUN_NOT_HALTED: assert property (@(posedge clk) disable iff (rst)
    running |-> !curHalt); // R2
  AST_RESET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    resetReq |=> resetReq); // R5
  AST_RESET_STOPS: assert property (@(posedge clk) disable iff (rst)
    resetReq |-> !running); // R5
  AST_RESET_NO_SMI: assert property (@(posedge clk) disable iff (rst)
    $rose(resetReq) |-> !smiPulse); // R5
  AST_RESET_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(resetReq) |-> $past(tick && !wrEn)); // R11
  AST_SMI_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    smiPulse |-> $past(tick || wrEn)); // R13
  AST_RELOAD_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.rldFromTmr, stb.rldFromBus, stb.rldDec, stb.rldClear})); // R7
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int          TMR_W      = 10,
  parameter int          ADDR_W     = 4,
  parameter logic [15:0] STAT1_MASK = 16'h0007,
  parameter logic [15:0] STAT2_MASK = 16'h0003,
  parameter logic [15:0] CTRL1_MASK = 16'h0003
) (
  input  logic              clk,
  input  logic              rst,
  input  wdogStrobes_t      stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        byteEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              curHalt,
  output logic [TMR_W-1:0]  tmrVal,
  output logic [TMR_W-1:0]  cntLow
);
  localparam logic [15:0] TMR_MASK  = 16'((32'd1 << TMR_W) - 1);
  localparam logic [15:0] LOCK_BIT  = 16'(1) << C1_LOCK;

  logic [15:0] rldQ, tmrQ, stat1Q, stat2Q, ctrl1Q, ctrl2Q;
  logic [7:0]  dinQ, doutQ, msg1Q, msg2Q, wdcntQ, swIrqQ;
  logic [15:0] set1, set2;

  function automatic logic [15:0] mergeLanes(input logic [15:0] oldV,
                                             input logic [15:0] newV,
                                             input logic [1:0]  be);
    logic [15:0] r;
    r[7:0]  = be[0] ? newV[7:0]  : oldV[7:0];
    r[15:8] = be[1] ? newV[15:8] : oldV[15:8];
    return r;
  endfunction

  always_comb begin
    set1 = '0;
    set2 = '0;
    set1[S1_TIMEOUT] = stb.setTimeout;
    set1[S1_SOFTSMI] = stb.setSoftSmi;
    set1[S1_DOUT]    = stb.setDoutInt;
    set2[S2_SECOND]  = stb.setSecond;
    set2[S2_BOOT]    = stb.setSecond;
  end

  // countdown / reload register
  always_ff @(posedge clk) begin
    if (rst) begin
      rldQ <= '0;
    end else if (stb.rldClear) begin
      rldQ <= '0;
    end else if (stb.rldFromTmr) begin
      rldQ <= tmrQ;
    end else if (stb.rldFromBus) begin
      rldQ <= mergeLanes(rldQ, wrData, byteEn);
    end else if (stb.rldDec) begin
      rldQ[TMR_W-1:0] <= rldQ[TMR_W-1:0] - TMR_W'(1);
    end
  end

  // halfword registers
  always_ff @(posedge clk) begin
    if (rst) begin
      tmrQ   <= 16'd4;
      stat1Q <= '0;
      stat2Q <= '0;
      ctrl1Q <= '0;
      ctrl2Q <= 16'h0008;
    end else begin
      if (stb.wrTimeout) tmrQ <= mergeLanes(tmrQ, wrData, byteEn) & TMR_MASK;
      if (stb.wrStat1) stat1Q <= mergeLanes(stat1Q, wrData, byteEn) & STAT1_MASK;
      else             stat1Q <= stat1Q | (set1 & STAT1_MASK);
      if (stb.wrStat2) stat2Q <= mergeLanes(stat2Q, wrData, byteEn) & STAT2_MASK;
      else             stat2Q <= stat2Q | (set2 & STAT2_MASK);
      if (stb.wrCtrl1)
        ctrl1Q <= (mergeLanes(ctrl1Q, wrData, byteEn) & CTRL1_MASK) | (ctrl1Q & LOCK_BIT);
      if (stb.wrCtrl2) ctrl2Q <= mergeLanes(ctrl2Q, wrData, byteEn);
    end
  end

  // byte registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dinQ   <= '0;
      doutQ  <= '0;
      msg1Q  <= '0;
      msg2Q  <= '0;
      wdcntQ <= '0;
      swIrqQ <= 8'h03;
    end else begin
      if (stb.wrDin)   dinQ   <= wrData[7:0];
      if (stb.wrDout)  doutQ  <= wrData[15:8];
      if (stb.wrMsg1)  msg1Q  <= wrData[7:0];
      if (stb.wrMsg2)  msg2Q  <= wrData[15:8];
      if (stb.wrWdcnt) wdcntQ <= wrData[7:0];
      if (stb.wrSwIrq) swIrqQ <= wrData[15:8];
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(HW_RELOAD):  rdData = rldQ;
      ADDR_W'(HW_TIMEOUT): rdData = tmrQ;
      ADDR_W'(HW_STAT1):   rdData = stat1Q;
      ADDR_W'(HW_STAT2):   rdData = stat2Q;
      ADDR_W'(HW_CTRL1):   rdData = ctrl1Q;
      ADDR_W'(HW_CTRL2):   rdData = ctrl2Q;
      ADDR_W'(HW_MAILBOX): rdData = {doutQ, dinQ};
      ADDR_W'(HW_MSG):     rdData = {msg2Q, msg1Q};
      ADDR_W'(HW_SCRATCH): rdData = {swIrqQ, wdcntQ};
      default:             rdData = '0;
    endcase
  end

  assign curHalt = ctrl1Q[C1_HALT];
  assign tmrVal  = tmrQ[TMR_W-1:0];
  assign cntLow  = rldQ[TMR_W-1:0];

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctrl1Q[C1_LOCK] |=> ctrl1Q[C1_LOCK]); // R8
  AST_SECOND_SETS_BOOT: assert property (@(posedge clk) disable iff (rst)
    stb.setSecond |=> stat2Q[S2_SECOND] && stat2Q[S2_BOOT]); // R5
  AST_EXPIRY_FLAGS: assert property (@(posedge clk) disable iff (rst)
    stb.setTimeout |=> stat1Q[S1_TIMEOUT]); // R4
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int          TMR_W      = 10,
  parameter int          ADDR_W     = 4,
  parameter logic [15:0] STAT1_MASK = 16'h0007,
  parameter logic [15:0] STAT2_MASK = 16'h0003,
  parameter logic [15:0] CTRL1_MASK = 16'h0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        byteEn,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic              spkrStrap,
  input  logic              noReboot,
  input  logic              smiEn,
  output logic              smiPulse,
  output logic              resetReq
);
  wdogStrobes_t     stb;
  logic             curHalt;
  logic [TMR_W-1:0] tmrVal;
  logic [TMR_W-1:0] cntLow;

  wdog_ctrl #(.TMR_W(TMR_W), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .byteEn(byteEn),
    .wrHalt(wrData[C1_HALT]), .tick(tick), .curHalt(curHalt),
    .tmrVal(tmrVal), .cntLow(cntLow), .spkrStrap(spkrStrap),
    .noReboot(noReboot), .smiEn(smiEn), .stb(stb),
    .smiPulse(smiPulse), .resetReq(resetReq)
  );

  wdog_datapath #(
    .TMR_W(TMR_W), .ADDR_W(ADDR_W), .STAT1_MASK(STAT1_MASK),
    .STAT2_MASK(STAT2_MASK), .CTRL1_MASK(CTRL1_MASK)
  ) i_datapath (
    .clk(clk), .rst(rst), .stb(stb), .addr(addr), .byteEn(byteEn),
    .wrData(wrData), .rdData(rdData), .curHalt(curHalt),
    .tmrVal(tmrVal), .cntLow(cntLow)
  );
endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [1:0] byteEn = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic spkrStrap = 1'b0, noReboot = 1'b0, smiEn = 1'b0;
  logic smiPulse, resetReq;

  int checks = 0;
  int fails = 0;

  // bench model state (random phase)
  logic [15:0] mRld, mTmr;
  logic mHalt, mRun, mExp, mSmi;

  always #10 clk = ~clk;

  wdog_two_stage #(.TMR_W(TW)) i_wdog_two_stage (
    .clk(clk), .rst(rst), .tick(tick), .wrEn(wrEn), .addr(addr),
    .byteEn(byteEn), .wrData(wrData), .rdData(rdData),
    .spkrStrap(spkrStrap), .noReboot(noReboot), .smiEn(smiEn),
    .smiPulse(smiPulse), .resetReq(resetReq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdData;
  endtask

  task automatic chkReg(input string req, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be,
                    input logic withTick);
    @(negedge clk);
    addr = a; wrData = d; byteEn = be; wrEn = 1'b1; tick = withTick;
    @(negedge clk);
    wrEn = 1'b0; byteEn = '0; tick = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // model of the countdown (strap held high in random phase)
  function automatic logic canRun();
    return !mHalt && (mTmr > 16'd1);
  endfunction

  task automatic mTick();
    mSmi = 1'b0;
    if (mRun) begin
      if (mRld[TW-1:0] <= 1) begin
        mExp = !mExp;
        mSmi = smiEn;
        mRld = mTmr;
      end else begin
        mRld[TW-1:0] = mRld[TW-1:0] - 1'b1;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: got hung expected done");
    summary();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    doReset();

    // R1 reset values
    chkReg("R1 reload", 4'd0, 16'h0000);
    chkReg("R1 timeout", 4'd1, 16'h0004);
    chkReg("R1 stat1", 4'd2, 16'h0000);
    chkReg("R1 stat2", 4'd3, 16'h0000);
    chkReg("R1 ctrl1", 4'd4, 16'h0000);
    chkReg("R1 ctrl2", 4'd5, 16'h0008);
    chkReg("R1 mailbox", 4'd6, 16'h0000);
    chkReg("R1 msg", 4'd7, 16'h0000);
    chkReg("R1 scratch", 4'd8, 16'h0300);
    check("R1 smi", {15'd0, smiPulse}, 16'd0);
    check("R1 resetReq", {15'd0, resetReq}, 16'd0);

    // R10 masks and byte lanes
    wr(4'd2, 16'hFFFF, 2'b11, 1'b0); chkReg("R10 stat1 mask", 4'd2, 16'h0007);
    wr(4'd3, 16'hFFFF, 2'b11, 1'b0); chkReg("R10 stat2 mask", 4'd3, 16'h0003);
    wr(4'd2, 16'h0000, 2'b11, 1'b0);
    wr(4'd3, 16'h0000, 2'b11, 1'b0);
    wr(4'd5, 16'h1234, 2'b10, 1'b0); chkReg("R10 ctrl2 lane", 4'd5, 16'h1208);
    wr(4'd7, 16'h55AA, 2'b01, 1'b0); chkReg("R10 msg lane", 4'd7, 16'h00AA);
    wr(4'd1, 16'hFF44, 2'b11, 1'b0); chkReg("R10 timeout width", 4'd1, 16'h0004);

    // R2 not running out of reset
    doTick(); chkReg("R2 idle after reset", 4'd0, 16'h0000);
    wr(4'd4, 16'h0000, 2'b11, 1'b0); chkReg("R2 ctrl1 start", 4'd0, 16'h0004);
    doTick(); chkReg("R3 count 3", 4'd0, 16'h0003);
    doTick(); chkReg("R3 count 2", 4'd0, 16'h0002);
    wr(4'd7, 16'h0000, 2'b11, 1'b1); chkReg("R11 tick during write", 4'd0, 16'h0002);
    wr(4'd4, 16'h0001, 2'b11, 1'b0);
    doTick(); chkReg("R2 halt stops", 4'd0, 16'h0002);
    wr(4'd0, 16'h1234, 2'b11, 1'b0); chkReg("R7 store when halted", 4'd0, 16'h1234);
    wr(4'd1, 16'h0001, 2'b11, 1'b0);
    wr(4'd4, 16'h0000, 2'b11, 1'b0); chkReg("R2 timeout 1 no start", 4'd0, 16'h1234);
    doTick(); chkReg("R2 timeout 1 idle", 4'd0, 16'h1234);

    // R8 lock
    wr(4'd4, 16'h0002, 2'b11, 1'b0);
    wr(4'd4, 16'h0000, 2'b11, 1'b0); chkReg("R8 lock sticky", 4'd4, 16'h0002);

    // R3 upper bits kept
    wr(4'd1, 16'h0005, 2'b11, 1'b0);
    wr(4'd4, 16'h0000, 2'b11, 1'b0); chkReg("R2 restart 5", 4'd0, 16'h0005);
    wr(4'd1, 16'h0001, 2'b11, 1'b0);
    wr(4'd0, 16'hA443, 2'b11, 1'b0);
    doTick(); chkReg("R3 upper preserved", 4'd0, 16'hA442);

    // R9 mailbox
    smiEn = 1'b0;
    wr(4'd6, 16'h0077, 2'b01, 1'b0);
    check("R9 data-in smi", {15'd0, smiPulse}, 16'd1);
    chkReg("R9 softsmi status", 4'd2, 16'h0002);
    wr(4'd6, 16'h8800, 2'b10, 1'b0);
    check("R9 data-out no smi", {15'd0, smiPulse}, 16'd0);
    chkReg("R9 dout status", 4'd2, 16'h0006);
    chkReg("R9 mailbox", 4'd6, 16'h8877);

    // R4 / R5 reset allowed
    doReset();
    smiEn = 1'b1; spkrStrap = 1'b0; noReboot = 1'b0;
    wr(4'd1, 16'h0003, 2'b11, 1'b0);
    wr(4'd4, 16'h0000, 2'b11, 1'b0);
    doTick(); doTick(); doTick();
    check("R4 first smi", {15'd0, smiPulse}, 16'd1);
    check("R4 no reset", {15'd0, resetReq}, 16'd0);
    chkReg("R4 timeout status", 4'd2, 16'h0001);
    chkReg("R4 reloaded", 4'd0, 16'h0003);
    doTick();
    check("R13 smi one cycle", {15'd0, smiPulse}, 16'd0);
    doTick(); doTick();
    check("R5 reset req", {15'd0, resetReq}, 16'd1);
    check("R5 no smi", {15'd0, smiPulse}, 16'd0);
    chkReg("R5 stat2", 4'd3, 16'h0003);
    chkReg("R5 cleared", 4'd0, 16'h0000);
    doTick(); doTick();
    check("R5 held", {15'd0, resetReq}, 16'd1);
    chkReg("R5 stopped", 4'd0, 16'h0000);

    // R6 strap blocks reset
    doReset();
    spkrStrap = 1'b1;
    wr(4'd1, 16'h0002, 2'b11, 1'b0);
    wr(4'd4, 16'h0000, 2'b11, 1'b0);
    doTick(); doTick(); doTick(); doTick();
    check("R6 strap no reset", {15'd0, resetReq}, 16'd0);
    check("R6 second smi", {15'd0, smiPulse}, 16'd1);
    chkReg("R6 stat2", 4'd3, 16'h0003);
    chkReg("R6 reloaded", 4'd0, 16'h0002);
    wr(4'd3, 16'h0000, 2'b11, 1'b0);
    doTick(); doTick();
    chkReg("R6 third is first", 4'd3, 16'h0000);

    // R6 / R12 no-reboot with SMI disabled
    doReset();
    spkrStrap = 1'b0; noReboot = 1'b1; smiEn = 1'b0;
    wr(4'd1, 16'h0002, 2'b11, 1'b0);
    wr(4'd4, 16'h0000, 2'b11, 1'b0);
    doTick(); doTick();
    check("R12 no smi", {15'd0, smiPulse}, 16'd0);
    chkReg("R12 status set", 4'd2, 16'h0001);
    doTick(); doTick();
    check("R6 noReboot no reset", {15'd0, resetReq}, 16'd0);
    chkReg("R6 noReboot stat2", 4'd3, 16'h0003);

    // R7 pet clears expiry count
    doReset();
    noReboot = 1'b0; smiEn = 1'b1;
    wr(4'd1, 16'h0002, 2'b11, 1'b0);
    wr(4'd4, 16'h0000, 2'b11, 1'b0);
    doTick(); doTick();
    wr(4'd0, 16'hFFFF, 2'b11, 1'b0); chkReg("R7 restart", 4'd0, 16'h0002);
    doTick(); doTick();
    check("R7 count cleared", {15'd0, resetReq}, 16'd0);
    chkReg("R7 stat2 clear", 4'd3, 16'h0000);

    // random phase against model
    doReset();
    spkrStrap = 1'b1;
    mRld = 0; mTmr = 16'd4; mHalt = 0; mRun = 0; mExp = 0; mSmi = 0;
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [15:0] d;
      op = int'($urandom % 8);
      smiEn = 1'($urandom);
      d = 16'($urandom);
      mSmi = 1'b0;
      if (op <= 4) begin
        doTick(); mTick();
      end else if (op == 5) begin
        wr(4'd0, d, 2'b11, 1'b0);
        mExp = 0;
        if (canRun()) begin mRld = mTmr; mRun = 1; end else mRld = d;
      end else if (op == 6) begin
        d = 16'($urandom % 8);
        wr(4'd1, d, 2'b11, 1'b0);
        mTmr = d;
      end else begin
        mHalt = (($urandom % 4) == 0);
        wr(4'd4, {15'd0, mHalt}, 2'b11, 1'b0);
        if (canRun()) begin mRld = mTmr; mRun = 1; end else mRun = 0;
      end
      check("R3 random smi", {15'd0, smiPulse}, {15'd0, mSmi});
      rd(4'd0, v);
      check("R7 random reload", v, mRld);
    end

    summary();
  end
endmodule